// File: doc/BRIEF.md
# Toggle Handshake Word Crossing

This block carries one data word at a time from a source clock domain into a destination clock domain. The two clocks are unrelated and asynchronous. The source side holds the word on a shared bus and flips a request level to announce it. The destination synchronizes that level and sees the change. It then latches the bus into a local register, shows the word with a single-cycle valid strobe, and copies the observed request level onto its acknowledge line. The acknowledge goes back through a synchronizer in the source clock. When the two levels agree again, the source is free to take the next word.

Users drive a send strobe with a word in the source domain, but only while the ready output is high. A strobe that arrives while a transfer is in flight is dropped. The destination logic consumes the word on the cycle its valid strobe is high. Each level change means one transfer, and no return-to-zero phase is needed, so a word costs one round trip through the synchronizers.

Top module: `toggle_xfer_cdc`

## Requirements
- R1: After reset, ready is 1 in the source domain and the valid strobe is 0 in the destination domain.
- R2: A send strobe sampled at a source clock edge while ready is 1 is accepted, and ready reads 0 in the source cycle right after that edge.
- R3: A send strobe sampled while ready is 0 is ignored: its word never appears at the destination output.
- R4: Every accepted word appears on the destination output exactly once, unchanged and in acceptance order.
- R5: The destination valid strobe lasts exactly one destination clock cycle per delivered word.
- R6: The destination word output holds its last delivered value while valid is 0.
- R7: Once a word has been delivered and acknowledged, ready returns to 1 without further stimulus.
- R8: The request level changes only on an accepted send, and the shared data bus stays unchanged for as long as a transfer is outstanding.
- R9: Delivery is correct whether the destination clock is faster than, slower than, or close to the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| send_i | input | 1 | Send strobe, source domain |
| send_data_i | input | WIDTH | Word offered with the send strobe |
| ready_o | output | 1 | High when no transfer is outstanding |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| word_valid_o | output | 1 | One-cycle strobe marking a delivered word |
| word_o | output | WIDTH | Last delivered word |

## Verification
The bench builds the block with a 16-bit word and three synchronizer stages rather than two. The deeper chain stretches each round trip and widens the windows in which a send strobe lands on a busy source. The narrower word keeps repeated random values likely, so each word is checked by its position in the order as well as its value. The destination period is set faster than, slower than, and close to the source period in turn. This puts capture and acknowledge edges at many phase offsets against the source edge.

// File: rtl/toggle_xfer_pkg.sv
package toggle_xfer_pkg;
    localparam int unsigned XFER_DEF_WIDTH  = 32;
    localparam int unsigned XFER_DEF_STAGES = 2;

    function automatic logic levels_differ(input logic a, input logic b);
        return a ^ b;
    endfunction
endpackage

// File: rtl/tgx_sync.sv
module tgx_sync #(
    parameter int unsigned STAGES = toggle_xfer_pkg::XFER_DEF_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[TOP-1:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[TOP];
endmodule

// File: rtl/tgx_src.sv
module tgx_src #(
    parameter int unsigned WIDTH  = toggle_xfer_pkg::XFER_DEF_WIDTH,
    parameter int unsigned STAGES = toggle_xfer_pkg::XFER_DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             ack_async_i,
    output logic             req_o,
    output logic [WIDTH-1:0] bus_o,
    output logic             ready_o
);
    typedef struct packed {
        logic             req;
        logic [WIDTH-1:0] data;
    } src_state_t;

    src_state_t st_d, st_q;
    logic       ack_s;
    logic       idle;
    logic       take;

    tgx_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_async_i),
        .q_o   (ack_s)
    );

    always_comb begin
        idle = !toggle_xfer_pkg::levels_differ(st_q.req, ack_s);
        take = send_i && idle;
        st_d = st_q;
        if (take) begin
            st_d.data = data_i;
            st_d.req  = ~st_q.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o   = st_q.req;
    assign bus_o   = st_q.data;
    assign ready_o = idle;

    AST_REQ_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req != $past(st_q.req)) |-> $past(send_i && idle)); // R8

    AST_BUS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable(st_q.data)); // R8

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ready_o); // R2
endmodule

// File: rtl/tgx_dst.sv
module tgx_dst #(
    parameter int unsigned WIDTH  = toggle_xfer_pkg::XFER_DEF_WIDTH,
    parameter int unsigned STAGES = toggle_xfer_pkg::XFER_DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_async_i,
    input  logic [WIDTH-1:0] bus_i,
    output logic             ack_o,
    output logic             valid_o,
    output logic [WIDTH-1:0] word_o
);
    typedef struct packed {
        logic             ack;
        logic             valid;
        logic [WIDTH-1:0] word;
    } dst_state_t;

    dst_state_t st_d, st_q;
    logic       req_s;

    tgx_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_async_i),
        .q_o   (req_s)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (toggle_xfer_pkg::levels_differ(req_s, st_q.ack)) begin
            st_d.word  = bus_i;
            st_d.ack   = req_s;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o   = st_q.ack;
    assign valid_o = st_q.valid;
    assign word_o  = st_q.word;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid); // R5

    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.word)); // R6

    AST_ACK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ack != $past(st_q.ack)) |-> st_q.valid); // R4
endmodule

// File: rtl/toggle_xfer_cdc.sv
module toggle_xfer_cdc #(
    parameter int unsigned WIDTH  = toggle_xfer_pkg::XFER_DEF_WIDTH,
    parameter int unsigned STAGES = toggle_xfer_pkg::XFER_DEF_STAGES
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             send_i,
    input  logic [WIDTH-1:0] send_data_i,
    output logic             ready_o,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic             word_valid_o,
    output logic [WIDTH-1:0] word_o
);
    logic             req_lvl;
    logic             ack_lvl;
    logic [WIDTH-1:0] xfer_bus;

    tgx_src #(.WIDTH(WIDTH), .STAGES(STAGES)) u_src (
        .clk         (src_clk),
        .rst_n       (src_rst_n),
        .send_i      (send_i),
        .data_i      (send_data_i),
        .ack_async_i (ack_lvl),
        .req_o       (req_lvl),
        .bus_o       (xfer_bus),
        .ready_o     (ready_o)
    );

    tgx_dst #(.WIDTH(WIDTH), .STAGES(STAGES)) u_dst (
        .clk         (dst_clk),
        .rst_n       (dst_rst_n),
        .req_async_i (req_lvl),
        .bus_i       (xfer_bus),
        .ack_o       (ack_lvl),
        .valid_o     (word_valid_o),
        .word_o      (word_o)
    );
endmodule

// File: tb/toggle_xfer_cdc_tb_top.sv
`timescale 1ns/1ps
module toggle_xfer_cdc_tb_top;
    localparam int W  = 16;
    localparam int ST = 3;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic         send = 1'b0;
    logic [W-1:0] sdata = '0;
    logic         ready;
    logic         wvalid;
    logic [W-1:0] word;

    realtime dst_half = 3.5;
    int total = 0;
    int bad = 0;
    int src_cycles = 0;
    int delivered = 0;
    int accepted = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] last_word = '0;
    bit have_last = 1'b0;
    bit prev_valid = 1'b0;
    bit finished = 1'b0;

    toggle_xfer_cdc #(.WIDTH(W), .STAGES(ST)) dut_i (
        .src_clk      (src_clk),
        .src_rst_n    (src_rst_n),
        .send_i       (send),
        .send_data_i  (sdata),
        .ready_o      (ready),
        .dst_clk      (dst_clk),
        .dst_rst_n    (dst_rst_n),
        .word_valid_o (wvalid),
        .word_o       (word)
    );

    always #10 src_clk = ~src_clk;
    initial forever #(dst_half) dst_clk = ~dst_clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pick_word(input int kind);
        case (kind)
            0: return '0;
            1: return '1;
            2: return {W{2'b10}} >> 0;
            default: return W'($urandom);
        endcase
    endfunction

    // destination monitor: R4 R5 R6 R3
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (wvalid) begin
                check(!prev_valid, "R5", "valid longer than one cycle", 32'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected extra word", 32'(word), 0);
                end else begin
                    check(word == exp_q[0], "R4", "word mismatch", 32'(word), 32'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
                last_word = word;
                have_last = 1'b1;
                delivered++;
            end else if (have_last) begin
                check(word == last_word, "R6", "word changed without valid", 32'(word), 32'(last_word));
            end
            prev_valid = wvalid;
        end
    end

    task automatic do_reset(input realtime half);
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        send = 1'b0;
        #1;
        dst_half = half;
        exp_q.delete();
        have_last = 1'b0;
        prev_valid = 1'b0;
        delivered = 0;
        accepted = 0;
        repeat (4) @(negedge src_clk);
        repeat (4) @(negedge dst_clk);
        @(negedge dst_clk) dst_rst_n = 1'b1;
        @(negedge src_clk) src_rst_n = 1'b1;
        @(negedge src_clk);
        check(ready == 1'b1, "R1", "ready after reset", 32'(ready), 1);
        check(wvalid == 1'b0, "R1", "valid after reset", 32'(wvalid), 0);
    endtask

    task automatic run_phase(input int n_words, input int send_pct, input string tag);
        bit acc_prev = 1'b0;
        int guard = 0;
        while (accepted < n_words) begin
            @(negedge src_clk);
            if (acc_prev)
                check(ready == 1'b0, "R2", {tag, " ready after accept"}, 32'(ready), 0);
            send  = (($urandom % 100) < send_pct);
            sdata = pick_word(int'($urandom % 8));
            acc_prev = send && ready;
            if (acc_prev) begin
                exp_q.push_back(sdata);
                accepted++;
            end
        end
        @(negedge src_clk);
        if (acc_prev)
            check(ready == 1'b0, "R2", {tag, " ready after last accept"}, 32'(ready), 0);
        send = 1'b0;
        while ((exp_q.size() != 0 || !ready) && guard < 4000) begin
            @(negedge src_clk);
            guard++;
        end
        check(exp_q.size() == 0, "R4", {tag, " words left undelivered"}, 32'(exp_q.size()), 0);
        check(delivered == accepted, "R9", {tag, " delivered count"}, 32'(delivered), 32'(accepted));
        check(ready == 1'b1, "R7", {tag, " ready after drain"}, 32'(ready), 1);
    endtask

    // directed: hold send high so each return of ready is taken at once
    task automatic back_to_back(input int n_words);
        int guard = 0;
        int start = accepted;
        send = 1'b1;
        while (accepted - start < n_words) begin
            sdata = W'($urandom);
            if (ready) begin
                exp_q.push_back(sdata);
                accepted++;
            end
            @(negedge src_clk);
        end
        send = 1'b0;
        while (exp_q.size() != 0 && guard < 4000) begin
            @(negedge src_clk);
            guard++;
        end
        check(exp_q.size() == 0, "R3", "back-to-back extras or losses", 32'(exp_q.size()), 0);
        check(delivered == accepted, "R4", "back-to-back count", 32'(delivered), 32'(accepted));
    endtask

    always @(posedge src_clk) begin
        src_cycles++;
        if (src_cycles > 150000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", src_cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(3.5);
        run_phase(250, 60, "fast dst");
        back_to_back(40);
        do_reset(26.5);
        run_phase(150, 40, "slow dst");
        back_to_back(20);
        do_reset(10.3);
        run_phase(200, 80, "near dst");
        back_to_back(30);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule